// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Cycle

This block is a minimal single-accumulator processor. It steps through a fixed cycle. It fetches a word from its internal memory into the instruction register and advances the program counter. It then executes the instruction. It reads an operand word when the operation needs one. Last, it looks at an interrupt request line before it goes on to the next fetch. Instructions are 16 bits wide. The top four bits hold the operation and the low twelve bits hold a direct word address. Data words use sign-magnitude form: bit 15 is the sign, 1 meaning negative, and bits 14..0 are the magnitude.

When a request is present and interrupts are enabled, the interrupt check does several things at once. It copies the program counter and the accumulator into shadow registers, clears the enable flag, loads the program counter with a fixed handler address and raises a one-clock acknowledge. A return opcode in the handler brings back both saved values and enables interrupts again. Requests that arrive while interrupts are disabled are not lost as long as the line stays high. They are serviced at the check that follows the return.

The memory is a synchronous single-port array. Its size is set by a parameter, and only the low address bits of an instruction select a word. A write port is provided for preloading. It is honoured only while reset is held, so the program and data can be placed in memory before the processor starts.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, pc_o reads 0, acc_o reads 0, int_en_o reads 1, and halted_o and int_ack_o both read 0.
- R2: Every instruction begins by reading the word at the program counter. The operation is bits 15..12 and the address is bits 11..0. The program counter then rises by exactly one, unless a later step of the same instruction redirects it.
- R3: Opcode 0x1 loads the addressed memory word into the accumulator.
- R4: Opcode 0x2 writes the accumulator into the addressed memory word.
- R5: Opcode 0x5 adds the addressed word to the accumulator in sign-magnitude form. When the signs are equal, the magnitudes are summed modulo 2^15 and the sign is kept. When the signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. A zero magnitude always comes out with sign 0.
- R6: Opcodes other than 0x1, 0x2, 0x5, 0xE and 0xF change neither the accumulator nor the program counter sequence.
- R7: After each instruction, a high irq with interrupts enabled does the following: it saves pc and accumulator, sets pc_o to HANDLER_ADDR (0x100 by default), drops int_en_o, and pulses int_ack_o high for exactly one clock.
- R8: While int_en_o is 0, irq causes no acknowledge. A request still held when the handler returns is taken at the check that directly follows the return.
- R9: Opcode 0xE restores the saved pc and accumulator and sets int_en_o to 1.
- R10: Opcode 0xF halts the processor. halted_o goes to 1, and pc_o and acc_o hold their values. irq is then ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables the preload port |
| irq | input | 1 | Interrupt request, level sensitive |
| ld_we | input | 1 | Preload write strobe, used only during reset |
| ld_addr | input | MEM_AW | Preload word address |
| ld_data | input | 16 | Preload word |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 12 | Program counter |
| halted_o | output | 1 | Processor stopped by halt opcode |
| int_ack_o | output | 1 | One-clock pulse when an interrupt is taken |
| int_en_o | output | 1 | Interrupt enable flag |

## Verification
The assertions assume irq is synchronous to clk and is held until the acknowledge, so a request never appears and vanishes between two checks. They also assume programs only fetch and read memory words that were preloaded. The bench follows these rules. It changes irq only at falling edges and drops it only after it has seen int_ack_o. It writes every word a program touches while reset is high. Every program ends in a halt placed well inside the memory, so no fetch runs off into unwritten words.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned ADDR_W = WORD_W - OPC_W;

  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'h5;
  localparam logic [OPC_W-1:0] OP_RETI  = 4'hE;
  localparam logic [OPC_W-1:0] OP_HALT  = 4'hF;

  typedef enum logic [2:0] {
    S_FETCH,
    S_DECODE,
    S_EXEC,
    S_OPRD,
    S_INTCHK,
    S_HALT
  } cpu_state_e;
endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells_q[addr] <= wdata;
    rdata <= cells_q[addr];
  end
endmodule

// File: rtl/acc_smadd.sv
module acc_smadd #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum
);
  localparam int unsigned MW = DW - 1;

  logic          sa, sb, sgn;
  logic [MW-1:0] ma, mb, mag;

  always_comb begin
    sa = a[DW-1];
    sb = b[DW-1];
    ma = a[MW-1:0];
    mb = b[MW-1:0];
    if (sa == sb) begin
      mag = ma + mb;
      sgn = sa;
    end else if (ma >= mb) begin
      mag = ma - mb;
      sgn = sa;
    end else begin
      mag = mb - ma;
      sgn = sb;
    end
    if (mag == '0) sgn = 1'b0;
  end

  assign sum = {sgn, mag};
endmodule

// File: rtl/acc_irq_ctl.sv
module acc_irq_ctl #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chk_i,
  input  logic          irq_i,
  input  logic          reti_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] acc_i,
  output logic          take_o,
  output logic          ie_o,
  output logic          ack_o,
  output logic [AW-1:0] ret_pc_o,
  output logic [DW-1:0] ret_acc_o
);
  logic          ie_q, ack_q;
  logic [AW-1:0] sh_pc_q;
  logic [DW-1:0] sh_acc_q;

  assign take_o = chk_i & irq_i & ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q     <= 1'b1;
      ack_q    <= 1'b0;
      sh_pc_q  <= '0;
      sh_acc_q <= '0;
    end else begin
      ack_q <= take_o;
      if (take_o) begin
        ie_q     <= 1'b0;
        sh_pc_q  <= pc_i;
        sh_acc_q <= acc_i;
      end else if (reti_i) begin
        ie_q <= 1'b1;
      end
    end
  end

  assign ie_o      = ie_q;
  assign ack_o     = ack_q;
  assign ret_pc_o  = sh_pc_q;
  assign ret_acc_o = sh_acc_q;

  // R7: acknowledge lasts a single clock
  p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q);

  // R8: no acknowledge may follow a cycle with interrupts disabled
  p_no_ack_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    !ie_q |=> !ack_q);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned       MEM_AW       = 9,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic              ld_we,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic [WORD_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halted_o,
  output logic              int_ack_o,
  output logic              int_en_o
);
  localparam logic [ADDR_W-1:0] PC_ONE   = 1;
  localparam logic [WORD_W-1:0] NEG_ZERO = {1'b1, {(WORD_W-1){1'b0}}};

  cpu_state_e        state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q, acc_q;
  logic              halted_q;

  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] opnd;
  logic [ADDR_W-MEM_AW-1:0] unused_opnd_hi;

  logic              cpu_we, mem_we;
  logic [MEM_AW-1:0] cpu_addr, mem_addr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata, add_sum;

  logic              chk, reti, take, ie, ack;
  logic [ADDR_W-1:0] ret_pc;
  logic [WORD_W-1:0] ret_acc;

  assign opc            = ir_q[WORD_W-1:ADDR_W];
  assign opnd           = ir_q[ADDR_W-1:0];
  assign unused_opnd_hi = opnd[ADDR_W-1:MEM_AW];

  assign cpu_addr = (state_q == S_FETCH) ? pc_q[MEM_AW-1:0] : opnd[MEM_AW-1:0];
  assign cpu_we   = (state_q == S_EXEC) && (opc == OP_STORE);
  assign reti     = (state_q == S_EXEC) && (opc == OP_RETI);
  assign chk      = (state_q == S_INTCHK);

  assign mem_we    = rst ? ld_we   : cpu_we;
  assign mem_addr  = rst ? ld_addr : cpu_addr;
  assign mem_wdata = rst ? ld_data : acc_q;

  acc_ram #(.DW(WORD_W), .AW(MEM_AW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  acc_smadd #(.DW(WORD_W)) u_add (
    .a   (acc_q),
    .b   (mem_rdata),
    .sum (add_sum)
  );

  acc_irq_ctl #(.DW(WORD_W), .AW(ADDR_W)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .chk_i     (chk),
    .irq_i     (irq),
    .reti_i    (reti),
    .pc_i      (pc_q),
    .acc_i     (acc_q),
    .take_o    (take),
    .ie_o      (ie),
    .ack_o     (ack),
    .ret_pc_o  (ret_pc),
    .ret_acc_o (ret_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_FETCH;
      pc_q     <= '0;
      ir_q     <= '0;
      acc_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_FETCH:  state_q <= S_DECODE;
        S_DECODE: begin
          ir_q    <= mem_rdata;
          pc_q    <= pc_q + PC_ONE;
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          unique case (opc)
            OP_LOAD, OP_ADD: state_q <= S_OPRD;
            OP_RETI: begin
              pc_q    <= ret_pc;
              acc_q   <= ret_acc;
              state_q <= S_INTCHK;
            end
            OP_HALT: begin
              halted_q <= 1'b1;
              state_q  <= S_HALT;
            end
            default: state_q <= S_INTCHK;
          endcase
        end
        S_OPRD: begin
          acc_q   <= (opc == OP_ADD) ? add_sum : mem_rdata;
          state_q <= S_INTCHK;
        end
        S_INTCHK: begin
          if (take) pc_q <= HANDLER_ADDR;
          state_q <= S_FETCH;
        end
        S_HALT:  state_q <= S_HALT;
        default: state_q <= S_FETCH;
      endcase
    end
  end

  assign acc_o     = acc_q;
  assign pc_o      = pc_q;
  assign halted_o  = halted_q;
  assign int_ack_o = ack;
  assign int_en_o  = ie;

  // R2: the fetch step advances the program counter by one
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE) |=> (pc_q == $past(pc_q) + PC_ONE));

  // R5: an add never leaves negative zero in the accumulator
  p_pos_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_OPRD && opc == OP_ADD) |=> (acc_q != NEG_ZERO));

  // R7: acknowledge coincides with redirect to the handler and disable
  p_take_vector_r7: assert property (@(posedge clk) disable iff (rst)
    ack |-> (pc_q == HANDLER_ADDR && !ie));

  // R9: return restores the saved pc and re-enables interrupts
  p_reti_restore_r9: assert property (@(posedge clk) disable iff (rst)
    reti |=> (ie && pc_q == $past(ret_pc)));

  // R10: a halted processor stays frozen
  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> (halted_q && $stable(pc_q) && $stable(acc_q) && !ack));
endmodule

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;
  localparam int MEM_AW = 9;
  localparam int NVEC   = 8;
  // operand A, operand B, expected sign-magnitude sum
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h0005, 16'h0003, 16'h0008},
    {16'h8005, 16'h0003, 16'h8002},
    {16'h0005, 16'h8005, 16'h0000},
    {16'h8004, 16'h8006, 16'h800A},
    {16'h0002, 16'h8007, 16'h8005},
    {16'h8000, 16'h8000, 16'h0000},
    {16'h7FFF, 16'h0002, 16'h0001},
    {16'h1234, 16'h8234, 16'h1000}
  };

  logic clk = 1'b0, rst = 1'b1, irq = 1'b0, ld_we = 1'b0;
  logic [MEM_AW-1:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] acc_o;
  logic [11:0] pc_o;
  logic halted_o, int_ack_o, int_en_o;

  int n_chk = 0, n_bad = 0, ack_cnt = 0, cyc = 0;

  always #2.5 clk = ~clk;

  acc_cpu #(.MEM_AW(MEM_AW), .HANDLER_ADDR(12'h100)) i_acc_cpu (
    .clk(clk), .rst(rst), .irq(irq), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .acc_o(acc_o), .pc_o(pc_o), .halted_o(halted_o),
    .int_ack_o(int_ack_o), .int_en_o(int_en_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (!rst && int_ack_o) ack_cnt++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] d);
    ld_addr = a[MEM_AW-1:0];
    ld_data = d;
    ld_we   = 1'b1;
    @(negedge clk);
    ld_we   = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_halt();
    for (int n = 0; n < 2000 && !halted_o; n++) @(negedge clk);
  endtask

  task automatic wait_ack();
    for (int n = 0; n < 500 && !int_ack_o; n++) @(negedge clk);
  endtask

  task automatic load_irq_prog();
    put(12'h000, 16'h1080);
    put(12'h001, 16'h0000);
    put(12'h002, 16'h3000);
    put(12'h003, 16'h5081);
    put(12'h004, 16'hF000);
    put(12'h080, 16'h0007);
    put(12'h081, 16'h0001);
    put(12'h090, 16'h0100);
    put(12'h100, 16'h1090);
    put(12'h101, 16'h2091);
    put(12'h102, 16'hE000);
  endtask

  initial begin
    int extra;
    logic [15:0] acc_hold;
    logic [11:0] pc_hold;

    // R1: reset state
    hold_reset();
    @(negedge clk);
    chk("R1 pc", pc_o, 0);
    chk("R1 acc", acc_o, 0);
    chk("R1 int_en", int_en_o, 1);
    chk("R1 halted", halted_o, 0);
    chk("R1 ack", int_ack_o, 0);

    // Vector walk: LOAD A, ADD B, STORE C, LOAD Z, LOAD C, two no-ops, HALT
    for (int v = 0; v < NVEC; v++) begin
      hold_reset();
      chk("R1 pc after run", pc_o, 0);
      chk("R1 acc after run", acc_o, 0);
      put(12'h000, 16'h1080);
      put(12'h001, 16'h5081);
      put(12'h002, 16'h2082);
      put(12'h003, 16'h1083);
      put(12'h004, 16'h1082);
      put(12'h005, 16'h3081);
      put(12'h006, 16'h4080);
      put(12'h007, 16'hF000);
      put(12'h080, VEC[v][47:32]);
      put(12'h081, VEC[v][31:16]);
      put(12'h082, 16'hFFFF);
      put(12'h083, 16'h0000);
      rst = 1'b0;
      wait_halt();
      chk("R3 R4 R5 R6 sum via store and reload", acc_o, VEC[v][15:0]);
      chk("R2 R10 pc at halt", pc_o, 12'h008);
      chk("R10 halted", halted_o, 1);
    end

    // Interrupt taken, serviced, returned
    hold_reset();
    load_irq_prog();
    irq = 1'b1;
    ack_cnt = 0;
    rst = 1'b0;
    wait_ack();
    chk("R7 ack seen", int_ack_o, 1);
    chk("R7 pc to handler", pc_o, 12'h100);
    chk("R7 int_en cleared", int_en_o, 0);
    chk("R7 acc at take", acc_o, 16'h0007);
    @(negedge clk);
    chk("R7 ack one clock", int_ack_o, 0);
    irq = 1'b0;
    for (int n = 0; n < 500 && !int_en_o; n++) @(negedge clk);
    chk("R9 pc restored", pc_o, 12'h001);
    chk("R9 acc restored", acc_o, 16'h0007);
    chk("R9 int_en set", int_en_o, 1);
    wait_halt();
    chk("R6 R9 final acc", acc_o, 16'h0008);
    chk("R10 pc at halt", pc_o, 12'h005);
    chk("R7 ack count", ack_cnt, 1);

    // Request held through the handler stays pending
    hold_reset();
    load_irq_prog();
    irq = 1'b1;
    ack_cnt = 0;
    rst = 1'b0;
    wait_ack();
    chk("R7 first ack", int_ack_o, 1);
    extra = 0;
    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      if (int_ack_o) extra++;
      if (int_en_o) break;
    end
    chk("R8 no ack while disabled", extra, 0);
    @(negedge clk);
    chk("R8 pending taken after return", int_ack_o, 1);
    chk("R8 pc to handler again", pc_o, 12'h100);
    irq = 1'b0;
    wait_halt();
    chk("R8 final acc", acc_o, 16'h0008);
    chk("R8 ack count", ack_cnt, 2);

    // Halted processor ignores requests
    acc_hold = acc_o;
    pc_hold  = pc_o;
    irq = 1'b1;
    repeat (20) @(negedge clk);
    chk("R10 still halted", halted_o, 1);
    chk("R10 pc frozen", pc_o, pc_hold);
    chk("R10 acc frozen", acc_o, acc_hold);
    chk("R10 irq ignored", ack_cnt, 2);
    irq = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule